// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block turns 4-bit transmit nibbles into the three-level line symbol stream of a 100BASE-TX transmitter. It runs on the 125 MHz bit clock. It takes one nibble every five clocks and announces each sampling cycle on a strobe. Each nibble becomes a 5-bit code group. The sequencer frames every packet with a start pair of code groups in place of the first preamble octet, closes it with an end pair once transmit-enable drops, and fills all other time with idle groups.

Code groups leave the block most significant bit first. Each bit is XORed with an 11-bit self-synchronising scrambler sequence, then converted to NRZI, and finally mapped to a three-level MLT-3 level. For repeater use, two independent bypass inputs let a raw 5-bit symbol replace the encoder output, and let unscrambled bits reach the NRZI stage.

Top module: `tx100_enc_chain`

## Requirements
- R1: While rst_ni is low, mlt_o is level zero (2'b00) and nib_take_o is low. After release, nib_take_o first rises in the fifth clock cycle. The symbol sent right after reset is idle (11111).
- R2: nib_take_o is high for exactly one cycle in every five. The nibble inputs and bypass controls are sampled at the clock edge that ends that cycle. The symbol they select is sent over the next five bit times, MSB first.
- R3: When no frame is active and tx_en_i is low at a take, the idle code group 11111 is sent.
- R4: If tx_en_i is high at a take while idle, the group J (11000) is sent. At the following take the group K (10001) is sent whatever txd_i holds.
- R5: In a frame, each nibble is mapped as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: When tx_en_i is low at a take after K or data, T (01101) is sent, then R (00111), then idle. This also holds when tx_en_i falls during the K slot.
- R7: While enc_byp_i is high at a take, raw_sym_i is sent unchanged and tx_en_i and txd_i have no effect. The sequencer returns to idle, so a frame that begins after the bypass ends opens with J.
- R8: Each serial bit is XORed with the feedback bit s[10]^s[8] of an 11-bit register s (polynomial x^11+x^9+1). The register shifts left with the feedback bit entering at bit 0 on every clock, whether the scrambler is bypassed or not. It is loaded with the non-zero parameter SEED at reset.
- R9: For the symbol selected at a take with scr_byp_i high, the serial bits reach the NRZI stage unscrambled.
- R10: The NRZI stage toggles on a 1 bit. The output level steps through 0, +1, 0, -1 on each toggle and holds otherwise. Levels are coded 00 = 0, 01 = +1, 11 = -1; 10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable, sampled at take |
| txd_i | input | 4 | Transmit nibble, sampled at take |
| enc_byp_i | input | 1 | Send raw_sym_i instead of encoded nibble |
| raw_sym_i | input | 5 | Raw code group used in encoder bypass |
| scr_byp_i | input | 1 | Skip scrambling for the selected symbol |
| nib_take_o | output | 1 | High in the cycle whose closing edge samples the inputs |
| mlt_o | output | 2 | Line level: 00 zero, 01 plus, 11 minus |

## Verification
The bench builds the block with SEED set to 11'h001. With this sparse start value, a mistake in the tap positions or the shift direction disturbs the recovered symbols within the first few code groups after reset. The bench recovers bits from level changes and descrambles them with its own register model started from the same seed. This makes every transmitted symbol comparable against the expected code group. The cases covered are framing, all sixteen nibble codes, both bypass paths, an early tx_en_i drop in the K slot and a reset in the middle of the stream.

// File: rtl/tx100_pkg.sv
package tx100_pkg;
  localparam int NIB_W  = 4;
  localparam int SYM_W  = 5;
  localparam int LFSR_W = 11;
  localparam int TAP_HI = LFSR_W - 1;
  localparam int TAP_LO = 8;
  localparam int SLOT_W = $clog2(SYM_W);

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {SQ_IDLE, SQ_K, SQ_DATA, SQ_R} seq_e;

  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_POS  = 2'b01,
    LV_NEG  = 2'b11
  } lvl_e;

  function automatic logic [SYM_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tx100_seq.sv
module tx100_seq
  import tx100_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             enc_byp_i,
  input  logic [SYM_W-1:0] raw_sym_i,
  output logic [SYM_W-1:0] sym_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    sym_o   = CG_IDLE;
    if (enc_byp_i) begin
      sym_o   = raw_sym_i;
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (tx_en_i) begin
          sym_o   = CG_J;
          state_d = SQ_K;
        end
        SQ_K: begin
          sym_o   = CG_K;
          state_d = SQ_DATA;
        end
        SQ_DATA: if (tx_en_i) begin
          sym_o = enc_nib(txd_i);
        end else begin
          sym_o   = CG_T;
          state_d = SQ_R;
        end
        SQ_R: begin
          sym_o   = CG_R;
          state_d = SQ_IDLE;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SQ_IDLE;
    else if (take_i) state_q <= state_d;
  end

  a_r7_byp_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && enc_byp_i) |=> state_q == SQ_IDLE);
  a_r4_j_then_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !enc_byp_i && tx_en_i && state_q == SQ_IDLE) |=> state_q == SQ_K);
  a_r6_r_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && state_q == SQ_R) |=> state_q == SQ_IDLE);
  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(state_q));
endmodule

// File: rtl/tx100_ser.sv
module tx100_ser
  import tx100_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  output logic             take_o,
  output logic             bit_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SYM_W-1:0]  shr_q;

  assign take_o = (slot_q == SLOT_W'(SYM_W - 1));
  assign bit_o  = shr_q[SYM_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      shr_q  <= CG_IDLE;
    end else if (take_o) begin
      slot_q <= '0;
      shr_q  <= sym_i;
    end else begin
      slot_q <= slot_q + 1'b1;
      shr_q  <= {shr_q[SYM_W-2:0], 1'b0};
    end
  end

  a_r2_take_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  a_r2_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> slot_q == '0);
  a_r2_load_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> bit_o == $past(sym_i[SYM_W-1]));
endmodule

// File: rtl/tx100_scr.sv
module tx100_scr
  import tx100_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h7FF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byp_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb    = lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO];
  assign bit_o = byp_i ? bit_i : (bit_i ^ fb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  a_r8_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  a_r8_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lfsr_q[LFSR_W-1:1] == $past(lfsr_q[LFSR_W-2:0]));
endmodule

// File: rtl/tx100_line.sv
module tx100_line
  import tx100_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  output logic [1:0] lvl_o
);
  logic       nrzi_q, nrzi_d;
  logic [1:0] phase_q;

  assign nrzi_d = nrzi_q ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrzi_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      nrzi_q <= nrzi_d;
      if (nrzi_d != nrzi_q) phase_q <= phase_q + 1'b1;
    end
  end

  always_comb begin
    unique case (phase_q)
      2'd1:    lvl_o = LV_POS;
      2'd3:    lvl_o = LV_NEG;
      default: lvl_o = LV_ZERO;
    endcase
  end

  a_r10_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o != 2'b10);
  a_r10_hold_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_i |=> $stable(lvl_o));
  a_r10_step_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_i |=> !$stable(lvl_o));
  a_r10_no_pos_to_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o == LV_POS |=> lvl_o != LV_NEG);
endmodule

// File: rtl/tx100_enc_chain.sv
module tx100_enc_chain
  import tx100_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h7FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             enc_byp_i,
  input  logic [SYM_W-1:0] raw_sym_i,
  input  logic             scr_byp_i,
  output logic             nib_take_o,
  output logic [1:0]       mlt_o
);
  logic [SYM_W-1:0] sym;
  logic             take, ser_bit, scr_bit, scr_byp_q;

  // scrambler bypass follows the symbol it was sampled with
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   scr_byp_q <= 1'b0;
    else if (take) scr_byp_q <= scr_byp_i;
  end

  tx100_seq u_seq (
    .clk_i, .rst_ni, .take_i(take), .tx_en_i, .txd_i,
    .enc_byp_i, .raw_sym_i, .sym_o(sym)
  );

  tx100_ser u_ser (
    .clk_i, .rst_ni, .sym_i(sym), .take_o(take), .bit_o(ser_bit)
  );

  tx100_scr #(.SEED(SEED)) u_scr (
    .clk_i, .rst_ni, .byp_i(scr_byp_q), .bit_i(ser_bit), .bit_o(scr_bit)
  );

  tx100_line u_line (
    .clk_i, .rst_ni, .bit_i(scr_bit), .lvl_o(mlt_o)
  );

  assign nib_take_o = take;

  a_r1_seed_nonzero: assert property (@(posedge clk_i) SEED != '0);
endmodule

// File: tb/tx100_enc_chain_tb.sv
module tx100_enc_chain_tb;
  localparam time CLK_PERIOD = 8ns;
  localparam logic [10:0] SEED = 11'h001;
  localparam int NV = 40;
  localparam int NS = NV + 8;

  // {req[3:0], scr_byp, enc_byp, tx_en, txd[3:0], raw[4:0], exp[4:0]}
  localparam logic [20:0] VEC [0:NV-1] = '{
    {4'd3, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b11111},   // R3 idle
    {4'd4, 1'b0, 1'b0, 1'b1, 4'h5, 5'h00, 5'b11000},   // R4 J
    {4'd4, 1'b0, 1'b0, 1'b1, 4'h5, 5'h00, 5'b10001},   // R4 K, nibble ignored
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h0, 5'h00, 5'b11110},   // R5
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h1, 5'h00, 5'b01001},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'hA, 5'h00, 5'b10110},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'hF, 5'h00, 5'b11101},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h7, 5'h00, 5'b01111},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'hC, 5'h00, 5'b11010},
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h3, 5'h00, 5'b01101},   // R6 T
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h3, 5'h00, 5'b00111},   // R6 R
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b11111},
    {4'd9, 1'b1, 1'b0, 1'b0, 4'h0, 5'h00, 5'b11111},   // R9 unscrambled
    {4'd9, 1'b1, 1'b0, 1'b1, 4'h2, 5'h00, 5'b11000},
    {4'd9, 1'b1, 1'b0, 1'b1, 4'h2, 5'h00, 5'b10001},
    {4'd9, 1'b1, 1'b0, 1'b1, 4'h8, 5'h00, 5'b10010},
    {4'd9, 1'b1, 1'b0, 1'b1, 4'hD, 5'h00, 5'b11011},
    {4'd9, 1'b1, 1'b0, 1'b0, 4'h0, 5'h00, 5'b01101},
    {4'd8, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b00111},   // R8 scrambling resumes
    {4'd6, 1'b0, 1'b0, 1'b1, 4'h4, 5'h00, 5'b11000},   // R6 early drop
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h4, 5'h00, 5'b10001},
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h4, 5'h00, 5'b01101},
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b00111},
    {4'd7, 1'b0, 1'b1, 1'b1, 4'h9, 5'h15, 5'b10101},   // R7 raw
    {4'd7, 1'b0, 1'b1, 1'b0, 4'h0, 5'h00, 5'b00000},
    {4'd7, 1'b1, 1'b1, 1'b1, 4'h0, 5'h04, 5'b00100},
    {4'd7, 1'b0, 1'b1, 1'b1, 4'h6, 5'h0C, 5'b01100},
    {4'd7, 1'b0, 1'b0, 1'b1, 4'h6, 5'h00, 5'b11000},   // R7 restart with J
    {4'd4, 1'b0, 1'b0, 1'b1, 4'h6, 5'h00, 5'b10001},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h6, 5'h00, 5'b01110},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'hE, 5'h00, 5'b11100},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'hB, 5'h00, 5'b10111},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h9, 5'h00, 5'b10011},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h2, 5'h00, 5'b10100},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h3, 5'h00, 5'b10101},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h4, 5'h00, 5'b01010},
    {4'd5, 1'b0, 1'b0, 1'b1, 4'h5, 5'h00, 5'b01011},
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b01101},
    {4'd6, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b00111},
    {4'd3, 1'b0, 1'b0, 1'b0, 4'h0, 5'h00, 5'b11111}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tx_en_i, enc_byp_i, scr_byp_i;
  logic [3:0] txd_i;
  logic [4:0] raw_sym_i;
  logic       nib_take_o;
  logic [1:0] mlt_o;

  int checks = 0;
  int errors = 0;
  logic run = 1'b0;
  logic done = 1'b0;
  logic [4:0] exp_sym [0:NS-1];
  logic       sbyp    [0:NS-1];
  logic [3:0] req_of  [0:NS-1];

  tx100_enc_chain #(.SEED(SEED)) u_dut (
    .clk_i, .rst_ni, .tx_en_i, .txd_i, .enc_byp_i, .raw_sym_i,
    .scr_byp_i, .nib_take_o, .mlt_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream observer and table walker
  initial begin
    int k = 0;
    int t = 0;
    logic [10:0] l = SEED;
    logic [1:0]  prev = 2'b00;
    logic [4:0]  acc = '0;
    logic        bad_lvl = 1'b0;
    exp_sym[0] = 5'b11111; sbyp[0] = 1'b0; req_of[0] = 4'd1;
    forever begin
      @(negedge clk_i);
      if (run && !done) begin
        int b, m;
        logic bt, fb, pl, tk_ok;
        k++;
        b  = k - 1;
        m  = b / 5;
        if (mlt_o == 2'b10) bad_lvl = 1'b1;
        bt   = (mlt_o != prev);
        prev = mlt_o;
        fb   = l[10] ^ l[8];
        l    = {l[9:0], fb};
        pl   = sbyp[m] ? bt : (bt ^ fb);
        acc  = {acc[3:0], pl};
        if (b % 5 == 4 && m <= NV) begin
          chk(acc == exp_sym[m], $sformatf("R%0d symbol %0d", req_of[m], m),
              acc, exp_sym[m]);
          chk(!bad_lvl, "R10 level code", bad_lvl, 0);
          if (m == NV) done = 1'b1;
        end
        tk_ok = (nib_take_o == (k % 5 == 4));
        if (!tk_ok || k % 5 == 4) chk(tk_ok, "R2 take period", nib_take_o, k % 5 == 4);
        if (nib_take_o) begin
          t++;
          if (t <= NV) begin
            {req_of[t], scr_byp_i, enc_byp_i, tx_en_i, txd_i, raw_sym_i, exp_sym[t]} = VEC[t-1];
            sbyp[t] = scr_byp_i;
          end else begin
            {scr_byp_i, enc_byp_i, tx_en_i, txd_i, raw_sym_i} = '0;
            if (t < NS) begin
              exp_sym[t] = 5'b11111; sbyp[t] = 1'b0; req_of[t] = 4'd3;
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    {scr_byp_i, enc_byp_i, tx_en_i, txd_i, raw_sym_i} = '0;
    repeat (3) @(negedge clk_i);
    chk(mlt_o == 2'b00, "R1 reset level", mlt_o, 0);
    chk(nib_take_o == 1'b0, "R1 reset take", nib_take_o, 0);
    rst_ni = 1'b1;
    run    = 1'b1;
    wait (done);
    run = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    {scr_byp_i, enc_byp_i, tx_en_i, txd_i, raw_sym_i} = '0;
    @(negedge clk_i);
    chk(mlt_o == 2'b00, "R1 mid-stream reset level", mlt_o, 0);
    chk(nib_take_o == 1'b0, "R1 mid-stream reset take", nib_take_o, 0);
    rst_ni = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk_i);
      chk(nib_take_o == (i == 4), $sformatf("R1 first take at cycle %0d", i),
          nib_take_o, i == 4);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule